// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the register front end of a multi-channel DMA engine. Each channel index owns two mirrored register windows, one for the write direction and one for the read direction. A host reaches them over a simple 32-bit valid/ready bus. Through these windows the host turns a channel on, selects linked-list mode, loads a 64-bit list start address in two halves, sets the consumer cycle bits and rings a doorbell to start a transfer. The bank also keeps a two-bit channel state and an interrupt status with write-one-to-clear semantics.

The data mover sits on the engine side. It receives a channel-enable level, a linked-list mode level and a one-cycle start pulse for each window. It returns done and abort event pulses. The bank turns these events into per-window state, status bits and gated interrupt lines. There are separate local and remote lines for the done event and for the abort event.

Windows are numbered so that window `w = dir*NCH + ch`. `dir` is 0 for the write direction and 1 for the read direction. Every per-window output vector is indexed by `w`.

Top module: `dma_chan_regs`

## Requirements
- R1: The byte address `ch*0x200 + dir*0x100 + off` selects one window, where `ch` is taken from address bits above bit 8 and `dir` is address bit 8. The register offsets are:
  - enable at 0x00
  - doorbell at 0x04
  - list pointer low at 0x10 and high at 0x14
  - cycle sync at 0x18
  - control at 0x34
  - state at 0x80
  - interrupt status at 0x84
  - interrupt setup at 0x88
  - interrupt clear at 0x8C

  Any other offset reads zero and ignores writes.
- R2: `hst_ready` is always high. An accepted read returns `hst_rvalid` high together with its data exactly one cycle later. A write produces no `hst_rvalid`.
- R3: Read-back returns the stored bits and zero elsewhere:
  - enable keeps bit 0
  - each pointer half keeps all 32 bits
  - cycle sync keeps bits 1:0
  - control keeps bit 0
  - setup keeps bits 0 and 2 to 6

  Doorbell and clear always read zero. `ch_en_o` and `ll_mode_o` follow enable bit 0 and control bit 0.
- R4: Writing 1 to doorbell bit 0 while the window is enabled and its state is not 1 produces a start pulse one cycle wide in the cycle after the write, and the state becomes 1. The write is ignored while the window is disabled or its state is 1.
- R5: The state reads in bits 1:0 as follows: 0 after reset or disable, 1 while running, 3 after a done event, and 2 after an abort event. When done and abort arrive in the same cycle, abort wins.
- R6: Engine events act only while the state is 1. A done event sets interrupt status bit 0, and an abort event sets bit 2 instead.
- R7: Writing ones to bit 0 or bit 2 of the clear register clears the matching status bit. If an event sets that bit in the same cycle, the bit stays set.
- R8: Each interrupt line follows its status bit, gated by the setup register:
  - `irq_done_loc` = status bit 0 AND setup bit 4 AND NOT setup bit 0
  - `irq_done_rmt` uses setup bit 3 in place of bit 4
  - `irq_abort_loc` = status bit 2 AND setup bit 6 AND NOT setup bit 2
  - `irq_abort_rmt` uses setup bit 5 in place of bit 6
- R9: Writing 0 to enable bit 0 returns the state to 0 and drops any engine event in that cycle. The interrupt status bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_valid | input | 1 | Host request valid |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | AW (12) | Byte address |
| hst_wdata | input | 32 | Write data |
| hst_ready | output | 1 | Request accepted (always high) |
| hst_rvalid | output | 1 | Read data valid |
| hst_rdata | output | 32 | Read data |
| eng_done | input | 2*NCH | Done event per window |
| eng_abort | input | 2*NCH | Abort event per window |
| ch_en_o | output | 2*NCH | Enable level per window |
| ll_mode_o | output | 2*NCH | Linked-list mode per window |
| start_o | output | 2*NCH | Start pulse per window |
| irq_done_loc | output | 2*NCH | Local done interrupt |
| irq_done_rmt | output | 2*NCH | Remote done interrupt |
| irq_abort_loc | output | 2*NCH | Local abort interrupt |
| irq_abort_rmt | output | 2*NCH | Remote abort interrupt |

## Verification
Storage is tried with random data, written to random windows and registers and then read back. This separates correct bit masks and window selection from aliasing between the two directions or between channels.

Directed sequences drive the event paths through the following cases:
- a doorbell while disabled
- a doorbell while running
- a lone done event
- a lone abort event
- a simultaneous done and abort
- an event while idle
- a clear that collides with a new event
- a disable that collides with an event

Each case distinguishes a specific priority rule. A random loop then combines random setup words with random event kinds on random windows, which separates the four gating equations of the interrupt lines.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW = 9 + CW,
  localparam int NW = 2 * NCH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_valid,
  input  logic          hst_write,
  input  logic [AW-1:0] hst_addr,
  input  logic [31:0]   hst_wdata,
  output logic          hst_ready,
  output logic          hst_rvalid,
  output logic [31:0]   hst_rdata,
  input  logic [NW-1:0] eng_done,
  input  logic [NW-1:0] eng_abort,
  output logic [NW-1:0] ch_en_o,
  output logic [NW-1:0] ll_mode_o,
  output logic [NW-1:0] start_o,
  output logic [NW-1:0] irq_done_loc,
  output logic [NW-1:0] irq_done_rmt,
  output logic [NW-1:0] irq_abort_loc,
  output logic [NW-1:0] irq_abort_rmt
);
  localparam int WIW = $clog2(NW);

  localparam logic [7:0] OFF_EN   = 8'h00;
  localparam logic [7:0] OFF_DB   = 8'h04;
  localparam logic [7:0] OFF_LPL  = 8'h10;
  localparam logic [7:0] OFF_LPH  = 8'h14;
  localparam logic [7:0] OFF_CYC  = 8'h18;
  localparam logic [7:0] OFF_CTL  = 8'h34;
  localparam logic [7:0] OFF_ST   = 8'h80;
  localparam logic [7:0] OFF_IST  = 8'h84;
  localparam logic [7:0] OFF_SET  = 8'h88;
  localparam logic [7:0] OFF_CLR  = 8'h8C;

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_RUN  = 2'd1;
  localparam logic [1:0] ST_ERR  = 2'd2;
  localparam logic [1:0] ST_DONE = 2'd3;

  logic [7:0]     off;
  logic           dir;
  logic [CW-1:0]  ch;
  logic           hit;
  logic [WIW-1:0] widx;
  logic           wr_acc;
  logic           rd_acc;
  logic [31:0]    rd_word [NW];

  assign off    = hst_addr[7:0];
  assign dir    = hst_addr[8];
  assign ch     = hst_addr[AW-1:9];
  assign hit    = int'(ch) < NCH;
  assign widx   = dir ? WIW'(NCH) + WIW'(ch) : WIW'(ch);
  assign wr_acc = hst_valid && hst_write && hit;
  assign rd_acc = hst_valid && !hst_write;

  assign hst_ready = 1'b1;

  for (genvar i = 0; i < NW; i++) begin : g_win
    logic        en_q, ctl_q, st_q, ist_stop, ist_abt;
    logic [1:0]  cyc_q, state_q;
    logic [31:0] lpl_q, lph_q;
    logic [6:0]  setup_q;
    logic        sel, dis, ring, ev_abt, ev_done, clr_stop, clr_abt;

    assign sel      = wr_acc && (widx == WIW'(i));
    assign dis      = sel && off == OFF_EN && !hst_wdata[0];
    assign ring     = sel && off == OFF_DB && hst_wdata[0] && en_q && state_q != ST_RUN;
    assign ev_abt   = state_q == ST_RUN && !dis && eng_abort[i];
    assign ev_done  = state_q == ST_RUN && !dis && eng_done[i] && !eng_abort[i];
    assign clr_stop = sel && off == OFF_CLR && hst_wdata[0];
    assign clr_abt  = sel && off == OFF_CLR && hst_wdata[2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q     <= 1'b0;
        ctl_q    <= 1'b0;
        st_q     <= 1'b0;
        ist_stop <= 1'b0;
        ist_abt  <= 1'b0;
        cyc_q    <= 2'b0;
        state_q  <= ST_IDLE;
        lpl_q    <= '0;
        lph_q    <= '0;
        setup_q  <= '0;
      end else begin
        st_q <= ring;
        if (sel && off == OFF_EN)  en_q    <= hst_wdata[0];
        if (sel && off == OFF_CTL) ctl_q   <= hst_wdata[0];
        if (sel && off == OFF_CYC) cyc_q   <= hst_wdata[1:0];
        if (sel && off == OFF_LPL) lpl_q   <= hst_wdata;
        if (sel && off == OFF_LPH) lph_q   <= hst_wdata;
        if (sel && off == OFF_SET) setup_q <= hst_wdata[6:0] & 7'h7D;
        if (dis)          state_q <= ST_IDLE;
        else if (ev_abt)  state_q <= ST_ERR;
        else if (ev_done) state_q <= ST_DONE;
        else if (ring)    state_q <= ST_RUN;
        ist_stop <= (ist_stop && !clr_stop) || ev_done;
        ist_abt  <= (ist_abt && !clr_abt) || ev_abt;
      end
    end

    always_comb begin
      case (off)
        OFF_EN:  rd_word[i] = {31'b0, en_q};
        OFF_LPL: rd_word[i] = lpl_q;
        OFF_LPH: rd_word[i] = lph_q;
        OFF_CYC: rd_word[i] = {30'b0, cyc_q};
        OFF_CTL: rd_word[i] = {31'b0, ctl_q};
        OFF_ST:  rd_word[i] = {30'b0, state_q};
        OFF_IST: rd_word[i] = {29'b0, ist_abt, 1'b0, ist_stop};
        OFF_SET: rd_word[i] = {25'b0, setup_q};
        default: rd_word[i] = 32'b0;
      endcase
    end

    assign ch_en_o[i]       = en_q;
    assign ll_mode_o[i]     = ctl_q;
    assign start_o[i]       = st_q;
    assign irq_done_loc[i]  = ist_stop && setup_q[4] && !setup_q[0];
    assign irq_done_rmt[i]  = ist_stop && setup_q[3] && !setup_q[0];
    assign irq_abort_loc[i] = ist_abt && setup_q[6] && !setup_q[2];
    assign irq_abort_rmt[i] = ist_abt && setup_q[5] && !setup_q[2];

    // R4
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[i] |-> (state_q == ST_RUN && en_q));
    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[i] |=> !start_o[i]);
    // R5
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && eng_done[i] && !eng_abort[i] && !dis) |=> state_q == ST_DONE);
    // R5
    abort_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && eng_abort[i] && !dis) |=> state_q == ST_ERR);
    // R7
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && eng_done[i] && !eng_abort[i] && !dis) |=> ist_stop);
    // R9
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis |=> (state_q == ST_IDLE && !en_q && $stable(ist_stop) && $stable(ist_abt)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hst_rvalid <= 1'b0;
      hst_rdata  <= '0;
    end else begin
      hst_rvalid <= rd_acc;
      if (rd_acc) hst_rdata <= hit ? rd_word[widx] : 32'b0;
    end
  end

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> hst_rvalid);
  // R2
  write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !hst_rvalid);
  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && off == 8'h40) |=> hst_rdata == 32'b0);
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int NW = 2 * NCH;
  localparam int AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_valid = 1'b0, hst_write = 1'b0;
  logic [AW-1:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic hst_ready, hst_rvalid;
  logic [31:0] hst_rdata;
  logic [NW-1:0] eng_done = '0, eng_abort = '0;
  logic [NW-1:0] ch_en_o, ll_mode_o, start_o;
  logic [NW-1:0] irq_done_loc, irq_done_rmt, irq_abort_loc, irq_abort_rmt;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs #(.NCH(NCH)) uut (
    .clk, .rst_n, .hst_valid, .hst_write, .hst_addr, .hst_wdata,
    .hst_ready, .hst_rvalid, .hst_rdata, .eng_done, .eng_abort,
    .ch_en_o, .ll_mode_o, .start_o, .irq_done_loc, .irq_done_rmt,
    .irq_abort_loc, .irq_abort_rmt
  );

  function automatic logic [AW-1:0] adr(int w, logic [7:0] off);
    return AW'((w % NCH) * 512 + (w / NCH) * 256 + int'(off));
  endfunction

  function automatic logic [31:0] keep_mask(logic [7:0] off);
    case (off)
      8'h00, 8'h34: return 32'h1;
      8'h10, 8'h14: return 32'hFFFF_FFFF;
      8'h18: return 32'h3;
      8'h88: return 32'h7D;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] exp_irq(logic stop, logic abt, logic [6:0] s);
    return {stop & s[4] & ~s[0], stop & s[3] & ~s[0], abt & s[6] & ~s[2], abt & s[5] & ~s[2]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int w, logic [7:0] off, logic [31:0] d);
    @(negedge clk);
    hst_valid = 1; hst_write = 1; hst_addr = adr(w, off); hst_wdata = d;
    @(negedge clk);
    hst_valid = 0; hst_write = 0;
  endtask

  task automatic rd(int w, logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    hst_valid = 1; hst_write = 0; hst_addr = adr(w, off);
    @(negedge clk);
    hst_valid = 0;
    chk("R2 rvalid", 32'(hst_rvalid), 32'h1);
    d = hst_rdata;
  endtask

  task automatic ev(int w, logic d, logic a);
    @(negedge clk);
    eng_done[w] = d; eng_abort[w] = a;
    @(negedge clk);
    eng_done[w] = 0; eng_abort[w] = 0;
  endtask

  function automatic logic [3:0] irq_of(int w);
    return {irq_done_loc[w], irq_done_rmt[w], irq_abort_loc[w], irq_abort_rmt[w]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 reset state and write silence
    chk("R2 ready", 32'(hst_ready), 32'h1);
    chk("R5 reset outputs", {start_o, ch_en_o}, 32'h0);
    rd(3, 8'h80, r); chk("R5 reset state", r, 0);
    wr(3, 8'h10, 32'h1);
    chk("R2 no rvalid on write", 32'(hst_rvalid), 32'h0);

    // R1 window separation and unmapped offsets
    wr(2, 8'h10, 32'hAAAA_0001);
    wr(2 + NCH, 8'h10, 32'h5555_0002);
    rd(2, 8'h10, r); chk("R1 write dir window", r, 32'hAAAA_0001);
    rd(2 + NCH, 8'h10, r); chk("R1 read dir window", r, 32'h5555_0002);
    wr(2, 8'h40, 32'hFFFF_FFFF); rd(2, 8'h40, r); chk("R1 unmapped", r, 0);
    wr(2, 8'h08, 32'hFFFF_FFFF); rd(2, 8'h08, r); chk("R1 unmapped 08", r, 0);
    // R3 doorbell and clear read zero
    rd(2, 8'h04, r); chk("R3 doorbell reads zero", r, 0);
    rd(2, 8'h8C, r); chk("R3 clear reads zero", r, 0);

    // R4 doorbell while disabled ignored
    wr(5, 8'h04, 1);
    chk("R4 no start when disabled", 32'(start_o[5]), 0);
    rd(5, 8'h80, r); chk("R4 state stays idle", r, 0);
    wr(5, 8'h00, 1);
    wr(5, 8'h04, 1);
    chk("R4 start pulse", start_o, 32'(1 << 5));
    @(negedge clk); chk("R4 start one cycle", 32'(start_o[5]), 0);
    rd(5, 8'h80, r); chk("R4 running", r, 1);
    wr(5, 8'h04, 1);
    chk("R4 no start while running", 32'(start_o[5]), 0);

    // R5 R6 R8 done
    wr(5, 8'h88, 32'h18);
    ev(5, 1, 0);
    rd(5, 8'h80, r); chk("R5 done state", r, 3);
    rd(5, 8'h84, r); chk("R6 stop status", r, 1);
    chk("R8 done irq", 32'(irq_of(5)), 32'hC);
    wr(5, 8'h88, 32'h19);
    chk("R8 done masked", 32'(irq_of(5)), 0);
    // R6 event when not running ignored
    ev(5, 0, 1);
    rd(5, 8'h84, r); chk("R6 idle abort ignored", r, 1);
    // R7 clear
    wr(5, 8'h8C, 1);
    rd(5, 8'h84, r); chk("R7 w1c stop", r, 0);

    // R7 event wins against clear
    wr(5, 8'h04, 1);
    wr(5, 8'h8C, 5);
    @(negedge clk);
    hst_valid = 1; hst_write = 1; hst_addr = adr(5, 8'h8C); hst_wdata = 1; eng_done[5] = 1;
    @(negedge clk);
    hst_valid = 0; hst_write = 0; eng_done[5] = 0;
    rd(5, 8'h84, r); chk("R7 event wins", r, 1);

    // R5 abort wins over done
    wr(9, 8'h00, 1); wr(9, 8'h88, 32'h60); wr(9, 8'h04, 1);
    ev(9, 1, 1);
    rd(9, 8'h80, r); chk("R5 abort wins state", r, 2);
    rd(9, 8'h84, r); chk("R6 abort status", r, 4);
    chk("R8 abort irq", 32'(irq_of(9)), 32'h3);

    // R9 disable drops coincident event
    wr(9, 8'h04, 1);
    @(negedge clk);
    hst_valid = 1; hst_write = 1; hst_addr = adr(9, 8'h00); hst_wdata = 0; eng_done[9] = 1;
    @(negedge clk);
    hst_valid = 0; hst_write = 0; eng_done[9] = 0;
    rd(9, 8'h80, r); chk("R9 disable idles", r, 0);
    rd(9, 8'h84, r); chk("R9 status kept, event dropped", r, 4);
    chk("R9 enable low", 32'(ch_en_o[9]), 0);

    // R5 R8 random event scenarios
    for (int k = 0; k < 40; k++) begin
      int w = int'($urandom_range(NW - 1));
      logic [6:0] s = 7'($urandom) & 7'h7D;
      int kind = int'($urandom_range(2));
      logic es, ea;
      wr(w, 8'h00, 1); wr(w, 8'h88, 32'(s)); wr(w, 8'h8C, 5); wr(w, 8'h04, 1);
      ev(w, kind != 1, kind != 0);
      ea = (kind != 0); es = (kind == 0);
      rd(w, 8'h80, r); chk("R5 random state", r, ea ? 2 : 3);
      chk("R8 random irq", 32'(irq_of(w)), 32'(exp_irq(es, ea, s)));
      wr(w, 8'h00, 0);
    end

    // R1 R3 random storage
    for (int k = 0; k < 60; k++) begin
      int w = int'($urandom_range(NW - 1));
      logic [7:0] offs [6] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h34, 8'h88};
      logic [7:0] o = offs[$urandom_range(5)];
      logic [31:0] d = $urandom;
      wr(w, o, d);
      rd(w, o, r); chk("R3 readback", r, d & keep_mask(o));
      if (o == 8'h00) chk("R3 enable pin", 32'(ch_en_o[w]), 32'(d[0]));
      if (o == 8'h34) chk("R3 ll mode pin", 32'(ll_mode_o[w]), 32'(d[0]));
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule